// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block sits in a host-side flash controller. It runs after the controller has written the last bus cycle of a program or erase command sequence. The block then polls the flash until the operation ends. A start pulse captures three things: the poll address, the expected data word and whether the operation was an erase. The block then issues status reads on a simple request/acknowledge parallel bus. Each read goes to the captured address.

The toggling completion bit in the status word is not trusted alone. It can settle before the rest of the data lines. So once that bit shows its true value, the block makes one more read and compares the whole word. If the flash raises its internal-failure bit, the block checks the completion bit once more. A true value on that re-read counts as success. Otherwise the block writes the reset command, which returns the flash to array read, and reports a device failure. A programmable read budget ends polling with a timeout error, again after the reset command, if the flash never resolves. The result comes out as a single-cycle done or error pulse, with a cause code beside the error.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, bus_req_o, done_o, err_o and busy_o are all low.
- R2: A start_i pulse while idle captures addr_i, exp_data_i and erase_i. Every bus cycle of that operation uses the captured address. All cycles are reads (bus_we_o low), except the single reset-command write.
- R3: The completion bit is data bit 7. Its true value is exp_data_i[7] for a program and 1 for an erase. A status read with bit 7 true is always followed by exactly one confirm read. Bit 7 takes priority over the failure bit.
- R4: The confirm read is compared with the expected word. For a program the expected word is exp_data_i. For an erase it is all ones, and exp_data_i is ignored. On a match the block pulses done_o. On a mismatch it pulses err_o with cause 2 and writes no reset command.
- R5: The failure bit is data bit 5. If a status read shows it set while bit 7 is not true, the block makes one re-read. If bit 7 is true on that re-read, the operation goes on as in R3 and R4.
- R6: If bit 7 is still not true on that re-read, the block writes the reset command to the poll address and then pulses err_o with cause 0. The reset command is 0xF0 in the low byte and zero in the upper bits.
- R7: limit_i sets the maximum number of status reads in the main poll loop. A value of 0 acts as 1. Re-reads and confirm reads do not count against it. If the last allowed read shows neither bit 7 true nor bit 5 set, the block writes the reset command and pulses err_o with cause 1.
- R8: done_o and err_o are single-cycle pulses and never both high. The pulse comes in the first cycle that busy_o is low again. err_cause_o is valid during the err_o pulse.
- R9: A start_i pulse while busy_o is high has no effect. The running operation keeps its address and outcome, and only one result pulse is produced.
- R10: A bus request, with its address and write enable, stays stable until bus_ack_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin polling (pulse) |
| erase_i | input | 1 | 1 = erase operation, 0 = program |
| addr_i | input | AW | Poll address |
| exp_data_i | input | DW | Programmed data (program only) |
| limit_i | input | CW | Maximum main-loop status reads |
| bus_req_o | output | 1 | Bus cycle request |
| bus_we_o | output | 1 | 1 = write cycle |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | DW | Write data |
| bus_ack_i | input | 1 | Cycle complete; read data valid |
| bus_rdata_i | input | DW | Read data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Success pulse |
| err_o | output | 1 | Failure pulse |
| err_cause_o | output | 2 | 0 device fail, 1 read limit, 2 data mismatch |

## Verification
A wrong sequencer state first shows up as a wrong number of bus reads, which is visible within two cycles of the faulty acknowledge. A missing confirm read or re-read cuts the count by one. A skipped reset command removes the single write. A wrong state can also show as a done pulse where an error pulse with a specific cause was due, or the reverse. A miscounting read budget moves the timeout by whole reads, so sweeping the limit and the busy length one read at a time exposes off-by-one faults. A stale address register shows on bus_addr_o during the very next cycle.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_POLL,
    ST_RECHK,
    ST_CONFIRM,
    ST_RSTCMD
  } poll_state_e;

  typedef enum logic [1:0] {
    CAUSE_DEV_FAIL = 2'd0,
    CAUSE_LIMIT    = 2'd1,
    CAUSE_MISMATCH = 2'd2
  } fail_cause_e;
endpackage

// File: rtl/poll_status_eval.sv
module poll_status_eval #(
  parameter int DW       = 8,
  parameter int STAT_BIT = 7,
  parameter int FAIL_BIT = 5
) (
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] exp_i,
  input  logic          erase_i,
  output logic          stat_true_o,
  output logic          fail_set_o,
  output logic          word_ok_o
);
  logic [DW-1:0] want;
  logic          true_bit;

  always_comb begin
    want        = erase_i ? {DW{1'b1}} : exp_i;
    true_bit    = want[STAT_BIT];
    stat_true_o = (rdata_i[STAT_BIT] == true_bit);
    fail_set_o  = rdata_i[FAIL_BIT];
    word_ok_o   = (rdata_i == want);
  end
endmodule

// File: rtl/poll_budget.sv
module poll_budget #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] limit_i,
  input  logic          step_i,
  output logic          last_o
);
  logic [CW-1:0] cnt_q, lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= CW'(1);
    end else if (load_i) begin
      cnt_q <= '0;
      lim_q <= (limit_i == '0) ? CW'(1) : limit_i;
    end else if (step_i) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign last_o = ({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, lim_q};

  p_no_step_past_limit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> !last_o);
  p_count_in_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < lim_q);
endmodule

// File: rtl/poll_seq.sv
module poll_seq
  import flash_poll_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          erase_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] exp_data_i,
  input  logic          bus_ack_i,
  input  logic          stat_true_i,
  input  logic          fail_set_i,
  input  logic          word_ok_i,
  input  logic          budget_last_i,
  output logic          budget_load_o,
  output logic          budget_step_o,
  output logic [DW-1:0] exp_q_o,
  output logic          erase_q_o,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [1:0]    err_cause_o
);
  poll_state_e   state_q, state_d;
  fail_cause_e   cause_q, cause_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] exp_q;
  logic          erase_q;
  logic          done_d, err_d, done_q, err_q;
  logic          accept;

  assign accept = start_i && (state_q == ST_IDLE);

  always_comb begin
    state_d       = state_q;
    cause_d       = cause_q;
    done_d        = 1'b0;
    err_d         = 1'b0;
    budget_step_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_POLL;
      ST_POLL: if (bus_ack_i) begin
        if (stat_true_i)      state_d = ST_CONFIRM;
        else if (fail_set_i)  state_d = ST_RECHK;
        else if (budget_last_i) begin
          state_d = ST_RSTCMD;
          cause_d = CAUSE_LIMIT;
        end else budget_step_o = 1'b1;
      end
      ST_RECHK: if (bus_ack_i) begin
        if (stat_true_i) state_d = ST_CONFIRM;
        else begin
          state_d = ST_RSTCMD;
          cause_d = CAUSE_DEV_FAIL;
        end
      end
      ST_CONFIRM: if (bus_ack_i) begin
        state_d = ST_IDLE;
        if (word_ok_i) done_d = 1'b1;
        else begin
          err_d   = 1'b1;
          cause_d = CAUSE_MISMATCH;
        end
      end
      ST_RSTCMD: if (bus_ack_i) begin
        state_d = ST_IDLE;
        err_d   = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cause_q <= CAUSE_DEV_FAIL;
      addr_q  <= '0;
      exp_q   <= '0;
      erase_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
      done_q  <= done_d;
      err_q   <= err_d;
      if (accept) begin
        addr_q  <= addr_i;
        exp_q   <= exp_data_i;
        erase_q <= erase_i;
      end
    end
  end

  assign budget_load_o = accept;
  assign exp_q_o       = exp_q;
  assign erase_q_o     = erase_q;
  assign bus_req_o     = (state_q != ST_IDLE);
  assign bus_we_o      = (state_q == ST_RSTCMD);
  assign bus_addr_o    = addr_q;
  assign busy_o        = (state_q != ST_IDLE);
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign err_cause_o   = cause_q;

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ack_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));
  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(addr_q));
  p_single_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |=> !(done_o || err_o));
  p_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
  p_pulse_when_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> !busy_o);
  p_done_after_confirm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(state_q == ST_CONFIRM));
  p_rstcmd_then_err_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && bus_ack_i) |=> (err_o && err_cause_o != 2'd2));
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller #(
  parameter int          DW       = 8,
  parameter int          AW       = 20,
  parameter int          CW       = 16,
  parameter int          STAT_BIT = 7,
  parameter int          FAIL_BIT = 5,
  parameter logic [7:0]  RST_CMD  = 8'hF0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          erase_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] exp_data_i,
  input  logic [CW-1:0] limit_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic          bus_ack_i,
  input  logic [DW-1:0] bus_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [1:0]    err_cause_o
);
  localparam logic [DW-1:0] RstWord = DW'(RST_CMD);

  logic          stat_true, fail_set, word_ok;
  logic          b_load, b_step, b_last;
  logic [DW-1:0] exp_q;
  logic          erase_q;

  poll_status_eval #(.DW(DW), .STAT_BIT(STAT_BIT), .FAIL_BIT(FAIL_BIT)) u_eval (
    .rdata_i(bus_rdata_i), .exp_i(exp_q), .erase_i(erase_q),
    .stat_true_o(stat_true), .fail_set_o(fail_set), .word_ok_o(word_ok)
  );

  poll_budget #(.CW(CW)) u_budget (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(b_load), .limit_i(limit_i),
    .step_i(b_step), .last_o(b_last)
  );

  poll_seq #(.DW(DW), .AW(AW)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .erase_i(erase_i),
    .addr_i(addr_i), .exp_data_i(exp_data_i), .bus_ack_i(bus_ack_i),
    .stat_true_i(stat_true), .fail_set_i(fail_set), .word_ok_i(word_ok),
    .budget_last_i(b_last), .budget_load_o(b_load), .budget_step_o(b_step),
    .exp_q_o(exp_q), .erase_q_o(erase_q), .bus_req_o(bus_req_o),
    .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .err_cause_o(err_cause_o)
  );

  assign bus_wdata_o = bus_we_o ? RstWord : '0;

  p_wdata_on_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && bus_we_o) |-> (bus_wdata_o == RstWord));
endmodule

// File: tb/flash_done_poller_tb.sv
module flash_done_poller_tb_top;
  localparam int DW = 8, AW = 8, CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, erase = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] exp_d = '0;
  logic [CW-1:0] limit = '0;
  logic          req, we, busy, done, err;
  logic [AW-1:0] baddr;
  logic [DW-1:0] wdata;
  logic          ack = 1'b0;
  logic [DW-1:0] rdata = '0;
  logic [1:0]    cause;

  always #10 clk = ~clk;

  flash_done_poller #(.DW(DW), .AW(AW), .CW(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .erase_i(erase),
    .addr_i(addr), .exp_data_i(exp_d), .limit_i(limit),
    .bus_req_o(req), .bus_we_o(we), .bus_addr_o(baddr), .bus_wdata_o(wdata),
    .bus_ack_i(ack), .bus_rdata_i(rdata), .busy_o(busy), .done_o(done),
    .err_o(err), .err_cause_o(cause)
  );

  logic [DW-1:0] resp [16];
  int            n_rd, n_wr, checks, fails;
  logic [DW-1:0] last_w;
  logic [AW-1:0] want_addr;
  logic          addr_bad;

  // flash model: one-cycle acknowledge, canned read responses
  always @(posedge clk) begin
    if (req && !ack) begin
      ack <= 1'b1;
      if (baddr != want_addr) addr_bad <= 1'b1;
      if (we) begin
        n_wr   <= n_wr + 1;
        last_w <= wdata;
      end else begin
        rdata <= resp[(n_rd > 15) ? 15 : n_rd];
        n_rd  <= n_rd + 1;
      end
    end else ack <= 1'b0;
  end

  task automatic chk(input string req_tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, expv);
    end
  endtask

  // sc: 0 ok, 1 dq5 then pass, 2 dq5 fail, 3 timeout, 4 mismatch
  task automatic run(input bit er, input int sc, input int nb, input logic [DW-1:0] ed, output bit hung);
    logic [DW-1:0] full, busyw;
    int exp_rd, exp_wr, exp_kind, exp_cause, lim, cyc;
    bit dbl, got_done, got_err;
    logic [1:0] got_cause;
    full = er ? 8'hFF : ed;
    for (int i = 0; i < 16; i++) begin
      busyw = (full[7] ? 8'h00 : 8'h80) | ((i & 1) ? 8'h40 : 8'h00) | 8'h0A;
      resp[i] = busyw;
    end
    lim = nb + 3;
    exp_wr = 0; exp_cause = 0; exp_kind = 1;
    case (sc)
      0: begin resp[nb] = full; resp[nb+1] = full; exp_rd = nb + 2; end
      1: begin resp[nb] = resp[nb] | 8'h20; resp[nb+1] = full; resp[nb+2] = full; exp_rd = nb + 3; end
      2: begin resp[nb] = resp[nb] | 8'h20; resp[nb+1] = resp[nb+1] | 8'h20;
               exp_rd = nb + 2; exp_wr = 1; exp_kind = 2; exp_cause = 0; end
      3: begin lim = nb; exp_rd = (nb == 0) ? 1 : nb; exp_wr = 1; exp_kind = 2; exp_cause = 1; end
      default: begin resp[nb] = full; resp[nb+1] = full ^ 8'h01;
               exp_rd = nb + 2; exp_kind = 2; exp_cause = 2; end
    endcase
    @(negedge clk);
    n_rd = 0; n_wr = 0; last_w = '0; addr_bad = 1'b0;
    want_addr = AW'(8'h30 + sc * 8 + nb);
    addr = want_addr; erase = er; exp_d = ed; limit = CW'(lim); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    addr = ~want_addr; exp_d = ~ed; erase = ~er; limit = '0;
    got_done = 0; got_err = 0; got_cause = '0; dbl = 0; hung = 0;
    for (cyc = 0; cyc < 300; cyc++) begin
      if (done || err) break;
      if (cyc == 2 && busy) begin start = 1'b1; dbl = 1; end // R9
      @(negedge clk);
      start = 1'b0;
    end
    if (cyc >= 300) begin hung = 1; chk("watchdog", 1, 0); return; end
    got_done = done; got_err = err; got_cause = cause;
    chk("R8 busy low at pulse", int'(busy), 0);
    chk("R8 exclusive", int'(got_done && got_err), 0);
    chk(sc == 0 || sc == 1 ? "R4/R5 outcome" : "R4/R6/R7 outcome",
        got_done ? 1 : (got_err ? 2 : 0), exp_kind);
    if (exp_kind == 2)
      chk(sc == 2 ? "R6 cause" : (sc == 3 ? "R7 cause" : "R4 cause"), int'(got_cause), exp_cause);
    chk(sc == 3 ? "R7 read count" : (sc < 3 ? "R3/R5 read count" : "R3 read count"), n_rd, exp_rd);
    chk("R6 reset write count", n_wr, exp_wr);
    if (exp_wr == 1) chk("R6 reset data", int'(last_w), 8'hF0);
    chk("R2 address", int'(addr_bad), 0);
    @(negedge clk);
    chk("R8 single pulse", int'(done || err), 0);
    chk("R9 no second run", int'(busy), 0);
    if (dbl) chk("R9 reads unaffected", n_rd, exp_rd);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    bit hung;
    hung = 0;
    checks = 0; fails = 0; want_addr = '0; n_rd = 0; n_wr = 0; addr_bad = 0; last_w = '0;
    repeat (3) @(negedge clk);
    chk("R1 req", int'(req), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done/err", int'(done || err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", int'(req || busy), 0);
    for (int er = 0; er < 2 && !hung; er++)
      for (int sc = 0; sc < 5 && !hung; sc++)
        for (int nb = 0; nb < 4 && !hung; nb++)
          run(er[0], sc, nb, DW'(sc * 37 + nb * 91 + er * 13 + 5), hung);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule